// File: doc/BRIEF.md
# Decoder Stream Termination Sequencer

This block runs the closing sequence for an audio decoder that sits behind a register/stream port controller. A one-cycle start begins the sequence. The block first fetches a fill word from the decoder's internal memory. To do so it writes the target memory address into an address register and then reads a data register. It repeats this indirect read until two values agree, with a fixed limit on the number of reads.

The low byte of the fetched word is then used as the fill byte. The block streams a first batch of fill bytes, writes the mode register with the new-stream-mode and cancel bits set, and streams a second batch. No soft reset follows, so any code already loaded into the decoder is kept. The fetched word is shown on an output. A one-cycle done pulse marks the end of the sequence.

Every request to the port controller uses a single valid/ready command channel. The channel carries a kind code, a register address and a data word. Register reads are answered on a separate response strobe. The port controller and the audio data path are outside this block.

Top module: `term_stream_end`

## Requirements
- R1: A start pulse while idle starts the sequence and raises `busy_o` on the next cycle. `busy_o` then stays high until the sequence ends. A start pulse while busy has no effect: no extra commands and no second done pulse. While idle, `cmd_valid_o` is low.
- R2: A command is transferred on a cycle where `cmd_valid_o` and `cmd_ready_i` are both high. While `cmd_valid_o` is high and `cmd_ready_i` is low, the command's kind, register and data are held stable. The kind code is 0 for a register write, 1 for a register read and 2 for a stream byte. A stream byte is carried in `cmd_data_o[7:0]` with the upper bits zero.
- R3: Each indirect read is a register write to address 0x07 with data equal to the `mem_addr_i` value captured at start, followed by a register read of address 0x06. `rd_valid_i` is taken only while a read is outstanding and is ignored at any other time.
- R4: If the first two read values are equal, that value is used and exactly two indirect reads are made.
- R5: The third and fourth reads are compared with the second read value, not the first. If the third read equals the second, the fetch ends after three reads with that value.
- R6: If no comparison agrees, a fourth read is made and its value is used.
- R7: Every stream byte equals the low 8 bits of the fetched word. From the end of the fetch onward, `fill_word_o` shows the fetched word; it is 0 after reset.
- R8: Exactly 2052 fill bytes are sent first. They are followed by one register write to address 0x00 with data 0x0808, which is bit 11 (new stream mode) and bit 3 (cancel).
- R9: After the mode write, exactly 2048 fill bytes are sent. No further command follows.
- R10: `done_o` is high for exactly one cycle, the cycle after the last fill byte is transferred, and `busy_o` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, taken only while idle |
| mem_addr_i | input | 16 | Decoder memory address that holds the fill word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| fill_word_o | output | 16 | Fill word fetched by the last sequence |
| cmd_valid_o | output | 1 | Command request valid |
| cmd_ready_i | input | 1 | Port controller accepts the command |
| cmd_kind_o | output | 2 | 0 register write, 1 register read, 2 stream byte |
| cmd_reg_o | output | 8 | Register address for register commands |
| cmd_data_o | output | 16 | Write data, or stream byte in bits 7:0 |
| rd_valid_i | input | 1 | Register read response strobe |
| rd_data_i | input | 16 | Register read response data |

## Verification
The hardest paths to reach are the fetch outcomes where the first two reads disagree. These include the case where the third read matches the first read but not the second; that case must still go on to a fourth read. The bench's port-controller model returns a per-scenario list of read values, so each outcome is reached on purpose. The model also adds response latency and a ready pattern that stalls one cycle in three. One scenario injects a stray response strobe and a second start pulse in the middle of the first fill batch. The full event log and byte count are then checked to show that neither had any effect.

// File: rtl/term_seq_pkg.sv
// Shared widths and command types for the stream termination sequencer.
package term_seq_pkg;
    localparam int REG_W  = 8;
    localparam int DATA_W = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        CMD_REG_WR = 2'd0,
        CMD_REG_RD = 2'd1,
        CMD_STREAM = 2'd2
    } cmd_kind_e;

    typedef struct packed {
        logic              valid;
        cmd_kind_e         kind;
        logic [REG_W-1:0]  reg_addr;
        logic [DATA_W-1:0] wdata;
    } cmd_t;
endpackage

// File: rtl/term_fetch_stable.sv
// Indirect memory fetch with read-until-stable check.
// Each read writes the memory address register, then reads the memory data
// register and waits for the response. The first two values are compared.
// Every later value is compared with the second. The last permitted read is
// used if nothing agrees.
// Assumes: go_i is pulsed only while idle; cmd_ready_i is only meaningful
// while this block drives a valid command; MAX_READS >= 2.
module term_fetch_stable
    import term_seq_pkg::*;
#(
    parameter logic [REG_W-1:0] MADDR_REG = 8'h07,
    parameter logic [REG_W-1:0] MDATA_REG = 8'h06,
    parameter int               MAX_READS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [DATA_W-1:0] mem_addr_i,
    input  logic              cmd_ready_i,
    input  logic              rd_valid_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output cmd_t              cmd_o,
    output logic              fin_o,
    output logic [DATA_W-1:0] word_o
);
    localparam int RC_W = $clog2(MAX_READS + 1);

    typedef enum logic [1:0] {F_IDLE, F_ADDR, F_READ, F_WAIT} fstate_e;

    fstate_e           st_q;
    logic [RC_W-1:0]   nrd_q;
    logic [DATA_W-1:0] addr_q;
    logic [DATA_W-1:0] first_q;
    logic [DATA_W-1:0] ref_q;
    logic [DATA_W-1:0] word_q;
    logic              fin_q;
    logic              agree;
    logic              at_last;

    // Comparison for the value now arriving: the first pair, then against the second.
    always_comb begin
        if (nrd_q == RC_W'(1)) agree = (rd_data_i == first_q);
        else                   agree = (rd_data_i == ref_q);
        at_last = (nrd_q == RC_W'(MAX_READS - 1));
    end

    // Drive the address write or the data read for the current state.
    always_comb begin
        cmd_o = '{valid: 1'b0, kind: CMD_REG_WR, reg_addr: '0, wdata: '0};
        case (st_q)
            F_ADDR: begin
                cmd_o.valid    = 1'b1;
                cmd_o.kind     = CMD_REG_WR;
                cmd_o.reg_addr = MADDR_REG;
                cmd_o.wdata    = addr_q;
            end
            F_READ: begin
                cmd_o.valid    = 1'b1;
                cmd_o.kind     = CMD_REG_RD;
                cmd_o.reg_addr = MDATA_REG;
            end
            default: ;
        endcase
    end

    // Fetch state machine and the registers that hold read values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= F_IDLE;
            nrd_q   <= '0;
            addr_q  <= '0;
            first_q <= '0;
            ref_q   <= '0;
            word_q  <= '0;
            fin_q   <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            case (st_q)
                F_IDLE: begin
                    if (go_i) begin
                        addr_q <= mem_addr_i;
                        nrd_q  <= '0;
                        st_q   <= F_ADDR;
                    end
                end
                F_ADDR: if (cmd_ready_i) st_q <= F_READ;
                F_READ: if (cmd_ready_i) st_q <= F_WAIT;
                F_WAIT: begin
                    if (rd_valid_i) begin
                        nrd_q <= nrd_q + RC_W'(1);
                        if (nrd_q == '0) begin
                            first_q <= rd_data_i;
                            st_q    <= F_ADDR;
                        end else begin
                            if (nrd_q == RC_W'(1)) ref_q <= rd_data_i;
                            if (agree || at_last) begin
                                word_q <= rd_data_i;
                                fin_q  <= 1'b1;
                                st_q   <= F_IDLE;
                            end else begin
                                st_q <= F_ADDR;
                            end
                        end
                    end
                end
                default: st_q <= F_IDLE;
            endcase
        end
    end

    assign fin_o  = fin_q;
    assign word_o = word_q;
endmodule

// File: rtl/term_fill_count.sv
// Down-counter for one batch of fill bytes.
// Loading sets the batch length. Each transferred byte takes one off.
// last_o marks the final byte of the batch.
// Assumes: the load value is at least 1.
module term_fill_count #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             take_i,
    output logic             last_o
);
    logic [CNT_W-1:0] cnt_q;

    // Load a new batch length, or count down one transferred byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (take_i && (cnt_q != '0)) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/term_stream_end.sv
// Top of the stream termination sequencer.
// Sequence: stable fetch of the fill word, first fill batch, mode write with
// the cancel bits, second fill batch, then a one-cycle done pulse.
// Assumes: a port controller takes commands by valid/ready and answers each
// register read with one rd_valid_i strobe, no earlier than the cycle after
// the read is transferred.
module term_stream_end
    import term_seq_pkg::*;
#(
    parameter logic [REG_W-1:0] MODE_REG    = 8'h00,
    parameter logic [REG_W-1:0] MDATA_REG   = 8'h06,
    parameter logic [REG_W-1:0] MADDR_REG   = 8'h07,
    parameter int               SDINEW_BIT  = 11,
    parameter int               CANCEL_BIT  = 3,
    parameter int               FIRST_FILL  = 2052,
    parameter int               SECOND_FILL = 2048,
    parameter int               MAX_READS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] mem_addr_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] fill_word_o,
    output logic              cmd_valid_o,
    input  logic              cmd_ready_i,
    output logic [1:0]        cmd_kind_o,
    output logic [REG_W-1:0]  cmd_reg_o,
    output logic [DATA_W-1:0] cmd_data_o,
    input  logic              rd_valid_i,
    input  logic [DATA_W-1:0] rd_data_i
);
    localparam int MAX_FILL = (FIRST_FILL > SECOND_FILL) ? FIRST_FILL : SECOND_FILL;
    localparam int CNT_W    = $clog2(MAX_FILL + 1);
    localparam logic [DATA_W-1:0] CANCEL_WORD =
        DATA_W'((1 << SDINEW_BIT) | (1 << CANCEL_BIT));

    typedef enum logic [2:0] {S_IDLE, S_FETCH, S_FILL1, S_CANCEL, S_FILL2} sstate_e;

    sstate_e           st_q;
    logic              done_q;
    logic [DATA_W-1:0] fill_word_q;
    cmd_t              fetch_cmd;
    cmd_t              out_cmd;
    logic              fetch_fin;
    logic [DATA_W-1:0] fetch_word;
    logic              fetch_go;
    logic              accept;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_load_val;
    logic              cnt_take;
    logic              cnt_last;

    term_fetch_stable #(
        .MADDR_REG (MADDR_REG),
        .MDATA_REG (MDATA_REG),
        .MAX_READS (MAX_READS)
    ) u_fetch (
        .clk         (clk),
        .rst_n       (rst_n),
        .go_i        (fetch_go),
        .mem_addr_i  (mem_addr_i),
        .cmd_ready_i (cmd_ready_i),
        .rd_valid_i  (rd_valid_i),
        .rd_data_i   (rd_data_i),
        .cmd_o       (fetch_cmd),
        .fin_o       (fetch_fin),
        .word_o      (fetch_word)
    );

    term_fill_count #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (cnt_load_val),
        .take_i     (cnt_take),
        .last_o     (cnt_last)
    );

    // Select which command reaches the port for the current phase.
    always_comb begin
        out_cmd = '{valid: 1'b0, kind: CMD_REG_WR, reg_addr: '0, wdata: '0};
        case (st_q)
            S_FETCH: out_cmd = fetch_cmd;
            S_FILL1, S_FILL2: begin
                out_cmd.valid = 1'b1;
                out_cmd.kind  = CMD_STREAM;
                out_cmd.wdata = {{(DATA_W-BYTE_W){1'b0}}, fill_word_q[BYTE_W-1:0]};
            end
            S_CANCEL: begin
                out_cmd.valid    = 1'b1;
                out_cmd.kind     = CMD_REG_WR;
                out_cmd.reg_addr = MODE_REG;
                out_cmd.wdata    = CANCEL_WORD;
            end
            default: ;
        endcase
    end

    // Handshake and batch-counter control derived from the phase.
    always_comb begin
        accept       = out_cmd.valid && cmd_ready_i;
        fetch_go     = (st_q == S_IDLE) && start_i;
        cnt_take     = accept && ((st_q == S_FILL1) || (st_q == S_FILL2));
        cnt_load     = ((st_q == S_FETCH) && fetch_fin) || ((st_q == S_CANCEL) && accept);
        cnt_load_val = (st_q == S_FETCH) ? CNT_W'(FIRST_FILL) : CNT_W'(SECOND_FILL);
    end

    // Phase sequencing, done pulse and the captured fill word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= S_IDLE;
            done_q      <= 1'b0;
            fill_word_q <= '0;
        end else begin
            done_q <= 1'b0;
            case (st_q)
                S_IDLE:   if (start_i) st_q <= S_FETCH;
                S_FETCH: begin
                    if (fetch_fin) begin
                        fill_word_q <= fetch_word;
                        st_q        <= S_FILL1;
                    end
                end
                S_FILL1:  if (accept && cnt_last) st_q <= S_CANCEL;
                S_CANCEL: if (accept) st_q <= S_FILL2;
                S_FILL2: begin
                    if (accept && cnt_last) begin
                        done_q <= 1'b1;
                        st_q   <= S_IDLE;
                    end
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    assign busy_o      = (st_q != S_IDLE);
    assign done_o      = done_q;
    assign fill_word_o = fill_word_q;
    assign cmd_valid_o = out_cmd.valid;
    assign cmd_kind_o  = out_cmd.kind;
    assign cmd_reg_o   = out_cmd.reg_addr;
    assign cmd_data_o  = out_cmd.wdata;
endmodule

// File: rtl/term_stream_end_chk.sv
// Protocol checker for the stream termination sequencer, bound to the top.
// Assumes: the same parameter values as the bound instance.
module term_stream_end_chk #(
    parameter logic [7:0]  MODE_REG    = 8'h00,
    parameter logic [7:0]  MDATA_REG   = 8'h06,
    parameter logic [15:0] CANCEL_WORD = 16'h0808
) (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic        busy_o,
    input logic        done_o,
    input logic        cmd_valid_o,
    input logic        cmd_ready_i,
    input logic [1:0]  cmd_kind_o,
    input logic [7:0]  cmd_reg_o,
    input logic [15:0] cmd_data_o
);
    // R1: a start while idle makes the block busy on the next cycle
    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);

    // R1: no command is offered while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !cmd_valid_o);

    // R2: a stalled command stays put
    p_hold_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_kind_o)
            && $stable(cmd_reg_o) && $stable(cmd_data_o)));

    // R3: register reads only target the memory data register
    p_read_reg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_kind_o == 2'd1) |-> (cmd_reg_o == MDATA_REG));

    // R8: a write to the mode register always carries the cancel word
    p_cancel_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_kind_o == 2'd0 && cmd_reg_o == MODE_REG)
            |-> (cmd_data_o == CANCEL_WORD));

    // R10: done lasts one cycle and comes with busy low
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
endmodule

bind term_stream_end term_stream_end_chk #(
    .MODE_REG    (MODE_REG),
    .MDATA_REG   (MDATA_REG),
    .CANCEL_WORD (CANCEL_WORD)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ready_i (cmd_ready_i),
    .cmd_kind_o  (cmd_kind_o),
    .cmd_reg_o   (cmd_reg_o),
    .cmd_data_o  (cmd_data_o)
);

// File: tb/term_stream_end_test.sv
// Directed bench: a port-controller model answers reads from a per-scenario
// list, logs every transferred command, and each scenario task checks the log.
module term_stream_end_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] mem_addr_i = '0;
    logic        busy_o, done_o;
    logic [15:0] fill_word_o;
    logic        cmd_valid_o;
    logic        cmd_ready_i = 1'b0;
    logic [1:0]  cmd_kind_o;
    logic [7:0]  cmd_reg_o;
    logic [15:0] cmd_data_o;
    logic        rd_valid_i = 1'b0;
    logic [15:0] rd_data_i = '0;

    int total = 0;
    int bad = 0;

    // model state
    logic [15:0] rd_vals [4];
    int rd_idx, rd_wait, rd_lat, rdy_mode, cyc;
    bit rd_pend, spur_req;
    logic [7:0] exp_byte;
    int n_bytes, bad_bytes, n_ev, done_cnt, done_cyc, last_acc;
    bit busy_at_done;
    logic [1:0]  ev_kind [32];
    logic [7:0]  ev_reg  [32];
    logic [15:0] ev_data [32];
    int          ev_pos  [32];

    always #10 clk = ~clk;

    term_stream_end uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mem_addr_i(mem_addr_i),
        .busy_o(busy_o), .done_o(done_o), .fill_word_o(fill_word_o),
        .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
        .cmd_kind_o(cmd_kind_o), .cmd_reg_o(cmd_reg_o), .cmd_data_o(cmd_data_o),
        .rd_valid_i(rd_valid_i), .rd_data_i(rd_data_i)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Port-controller model, acting on falling edges.
    initial begin
        cyc = 0; rd_pend = 0; spur_req = 0; rdy_mode = 0; rd_lat = 0;
        forever begin
            @(negedge clk);
            cyc++;
            rd_valid_i = 1'b0;
            if (rd_pend) begin
                if (rd_wait == 0) begin
                    rd_valid_i = 1'b1;
                    rd_data_i  = rd_vals[rd_idx];
                    rd_idx++;
                    rd_pend = 0;
                end else rd_wait--;
            end else if (spur_req) begin
                rd_valid_i = 1'b1;
                rd_data_i  = 16'hDEAD;
                spur_req   = 0;
            end
            cmd_ready_i = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 1);
            if (cmd_valid_o && cmd_ready_i) begin
                if (cmd_kind_o == 2'd2) begin
                    n_bytes++;
                    last_acc = cyc;
                    if (cmd_data_o != {8'h00, exp_byte}) bad_bytes++;
                end else begin
                    if (n_ev < 32) begin
                        ev_kind[n_ev] = cmd_kind_o;
                        ev_reg[n_ev]  = cmd_reg_o;
                        ev_data[n_ev] = cmd_data_o;
                        ev_pos[n_ev]  = n_bytes;
                    end
                    n_ev++;
                    if (cmd_kind_o == 2'd1) begin
                        rd_pend = 1;
                        rd_wait = rd_lat;
                    end
                end
            end
            if (done_o) begin
                done_cnt++;
                done_cyc = cyc;
                busy_at_done = busy_o;
            end
        end
    end

    // One full sequence with given read values, pacing and optional disturbance.
    task automatic run_seq(input string tag, input logic [15:0] v0, input logic [15:0] v1,
                           input logic [15:0] v2, input logic [15:0] v3,
                           input int exp_reads, input logic [15:0] exp_word,
                           input logic [15:0] addr, input int rmode, input int lat,
                           input bit poke);
        int waited;
        int bad_ev;
        rd_vals[0] = v0; rd_vals[1] = v1; rd_vals[2] = v2; rd_vals[3] = v3;
        rd_idx = 0; rd_pend = 0; rd_lat = lat; rdy_mode = rmode;
        exp_byte = exp_word[7:0];
        n_bytes = 0; bad_bytes = 0; n_ev = 0; done_cnt = 0; done_cyc = -1; last_acc = -9;
        busy_at_done = 1;
        @(negedge clk);
        mem_addr_i = addr;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        mem_addr_i = 16'hFFFF;
        check(busy_o == 1'b1, {tag, " R1 busy after start"}, busy_o, 1);
        waited = 0;
        while (done_cnt == 0 && waited < 20000) begin
            @(negedge clk);
            waited++;
            if (poke && waited == 150) start_i = 1'b1;
            if (poke && waited == 151) start_i = 1'b0;
            if (poke && waited == 300) spur_req = 1;
        end
        repeat (20) @(negedge clk);
        check(done_cnt == 1, {tag, " R10 done pulse count"}, done_cnt, 1);
        check(done_cyc == last_acc + 1, {tag, " R10 done timing"}, done_cyc, last_acc + 1);
        check(!busy_at_done, {tag, " R10 busy low at done"}, busy_at_done, 0);
        check(busy_o == 1'b0, {tag, " R1 idle after sequence"}, busy_o, 0);
        check(n_ev == 2 * exp_reads + 1, {tag, " R3 register command count"},
              n_ev, 2 * exp_reads + 1);
        bad_ev = 0;
        for (int i = 0; i < exp_reads && i < 15; i++) begin
            if (ev_kind[2*i] != 2'd0 || ev_reg[2*i] != 8'h07 || ev_data[2*i] != addr
                || ev_pos[2*i] != 0) bad_ev++;
            if (ev_kind[2*i+1] != 2'd1 || ev_reg[2*i+1] != 8'h06 || ev_pos[2*i+1] != 0) bad_ev++;
        end
        check(bad_ev == 0, {tag, " R3 indirect read pairs"}, bad_ev, 0);
        if (n_ev == 2 * exp_reads + 1) begin
            check(ev_kind[n_ev-1] == 2'd0 && ev_reg[n_ev-1] == 8'h00,
                  {tag, " R8 mode write target"}, {ev_kind[n_ev-1], ev_reg[n_ev-1]}, 0);
            check(ev_data[n_ev-1] == 16'h0808, {tag, " R8 cancel word"}, ev_data[n_ev-1], 16'h0808);
            check(ev_pos[n_ev-1] == 2052, {tag, " R8 first batch length"}, ev_pos[n_ev-1], 2052);
        end
        check(n_bytes - 2052 == 2048, {tag, " R9 second batch length"}, n_bytes - 2052, 2048);
        check(bad_bytes == 0, {tag, " R7 fill byte value"}, bad_bytes, 0);
        check(fill_word_o == exp_word, {tag, " R4/R5/R6 fetched word"}, fill_word_o, exp_word);
    endtask

    task automatic t_reset;
        check(busy_o == 1'b0, "R1 reset busy", busy_o, 0);
        check(done_o == 1'b0, "R10 reset done", done_o, 0);
        check(cmd_valid_o == 1'b0, "R1 reset idle command", cmd_valid_o, 0);
        check(fill_word_o == 16'h0, "R7 reset fill word", fill_word_o, 0);
    endtask

    // R4: first pair agrees
    task automatic t_first_pair;
        run_seq("first_pair", 16'h12AB, 16'h12AB, 16'h0, 16'h0, 2, 16'h12AB, 16'h1E06, 0, 0, 0);
    endtask

    // R5: third read matches the second
    task automatic t_third_match;
        run_seq("third_match", 16'h0001, 16'h5502, 16'h5502, 16'h0, 3, 16'h5502, 16'h0042, 1, 2, 0);
    endtask

    // R5/R6: third equals first only, so a fourth read decides
    task automatic t_ref_is_second;
        run_seq("ref_second", 16'h00A1, 16'h00B2, 16'h00A1, 16'h00C3, 4, 16'h00C3, 16'h1234, 0, 1, 0);
    endtask

    // R6: all different, last read used, under backpressure
    task automatic t_no_agree;
        run_seq("no_agree", 16'h1111, 16'h2222, 16'h3333, 16'h4444, 4, 16'h4444, 16'hBEEF, 1, 3, 0);
    endtask

    // R1/R3: start and a stray response during the fill have no effect
    task automatic t_disturb;
        run_seq("disturb", 16'h7E5A, 16'h7E5A, 16'h0, 16'h0, 2, 16'h7E5A, 16'h0777, 1, 1, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_first_pair();
        t_third_match();
        t_ref_is_second();
        t_no_agree();
        t_disturb();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule